// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synchronous behavioural model of the command side of a parallel flash device. Bus writes are recognised at the rising edge of the active-low write strobe, which is sampled on the system clock. A small decoder turns those writes into single-cycle commands or two-cycle operations. A write state machine then runs each accepted operation for a fixed, configurable number of clock cycles. Three operations exist: main-array program, one-time-programmable (OTP) program and block erase. While an operation runs, the ready/busy output is held low.

Programming can only clear bits, so the stored word becomes the AND of its old value and the written data. An 8-bit status word reports readiness and error causes. Each cause is checked when the operation is accepted: a missing programming voltage, a locked OTP area, or a write to a protected boot block. The write-protect pin guards exactly two boot blocks, either the two highest or the two lowest, chosen by a parameter. Error bits stay set until a clear command is written.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ry_by` is 1, the controller is in array-read mode, status reads 0x80, and every main and OTP word reads 0xFF.
- R2: Writing 0x40 and then an address/data cycle programs the main array. The new word is the old word ANDed with the data.
- R3: Writing 0xC0 and then an address/data cycle programs the OTP word at the low address bits, again as an AND. Command 0x90 selects OTP-read mode, in which `dout` returns that OTP word.
- R4: An accepted operation holds `ry_by` low and status bit 7 at 0 for exactly BUSY_CYCLES clock cycles, starting at the clock edge that sees the second write strobe rise.
- R5: After any two-cycle sequence, `dout` returns status until another mode command arrives. Command 0x70 selects status read and 0xFF selects array read.
- R6: If `vpp_ok` is low when an operation is accepted, the array is left unchanged. Status bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R7: An OTP program accepted while `otp_lock` is 1 sets status bits 1 and 4 and leaves the OTP word unchanged.
- R8: With `wp_n` low, a program or erase aimed at a boot block leaves the array unchanged. It sets bit 1 plus bit 4 for a program, or bit 1 plus bit 5 for an erase. Boot blocks are the top two of the 8-word blocks when TOP_BOOT=1 and the bottom two otherwise; the block index is the upper address bits.
- R9: With `wp_n` high, boot blocks program and erase normally. `wp_n` never affects non-boot blocks or the OTP area.
- R10: Writing 0x20 and then 0xD0 with an address sets every word of that address's block to 0xFF. If any other byte follows 0x20, status bits 4 and 5 are set and nothing runs.
- R11: Command 0x50 clears status bits 5, 4, 3 and 1. Until that happens, error bits accumulate across later operations.
- R12: Bus writes that arrive while busy are ignored, and the read mode stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Active-low write strobe; a write is taken at its rising edge |
| addr | input | ADDR_W | Word address for writes and reads |
| din | input | 8 | Write data or command byte |
| wp_n | input | 1 | Boot-block write protect, active low |
| vpp_ok | input | 1 | Programming voltage valid |
| otp_lock | input | 1 | OTP area locked |
| dout | output | 8 | Read data: status, main word or OTP word, depending on mode |
| ry_by | output | 1 | High when ready, low while an operation runs |

## Verification
The hardest case to reach is a write that arrives while an operation is still running. The strobe has to rise inside the BUSY_CYCLES window, after the edge that started the operation. The bench gets there by issuing a mode-changing command right after the second cycle of a program. Its three-cycle strobe lands before the fourth busy cycle ends. Afterwards the bench reads `dout` without writing any command, to show that status mode survived. A stimulus table then runs error combinations back to back. Error bits accumulate only when no clear sits between two failing operations.

// File: rtl/fcc_pkg.sv
// Package: shared types and command codes of the flash command controller.
// Assumes 8-bit command/data bus.
package fcc_pkg;
    localparam int DATA_W = 8;

    localparam logic [7:0] CMD_PROG      = 8'h40;
    localparam logic [7:0] CMD_OTP       = 8'hC0;
    localparam logic [7:0] CMD_ERASE     = 8'h20;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_CLEAR     = 8'h50;
    localparam logic [7:0] CMD_STATUS    = 8'h70;
    localparam logic [7:0] CMD_ARRAY     = 8'hFF;
    localparam logic [7:0] CMD_OTP_READ  = 8'h90;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_OTP   = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_OTP    = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PD_NONE  = 2'd0,
        PD_PROG  = 2'd1,
        PD_OTP   = 2'd2,
        PD_ERASE = 2'd3
    } pend_e;
endpackage

// File: rtl/fcc_decoder.sv
// Command decoder: detects the rising edge of the write strobe and turns
// bus writes into mode changes, clear pulses and operation starts.
// Assumes we_n is already synchronous to clk. Writes while busy are dropped.
module fcc_decoder
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              busy_i,
    output mode_e             mode_o,
    output logic              start_o,
    output op_e               op_o,
    output logic              clr_o,
    output logic              seq_err_o
);
    logic  we_q;
    logic  we_rise;
    logic  take;
    pend_e pend_q;
    mode_e mode_q;

    // strobe history for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign we_rise = we_n && !we_q;
    assign take    = we_rise && !busy_i;

    // second-cycle decode: starts, sequence errors and clear pulses
    always_comb begin
        start_o   = 1'b0;
        seq_err_o = 1'b0;
        clr_o     = 1'b0;
        op_o      = OP_PROG;
        if (take) begin
            unique case (pend_q)
                PD_PROG:  begin start_o = 1'b1; op_o = OP_PROG; end
                PD_OTP:   begin start_o = 1'b1; op_o = OP_OTP;  end
                PD_ERASE: begin
                    op_o = OP_ERASE;
                    if (din == CMD_CONFIRM) start_o = 1'b1;
                    else                    seq_err_o = 1'b1;
                end
                default:  clr_o = (din == CMD_CLEAR);
            endcase
        end
    end

    // pending-sequence and read-mode tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= PD_NONE;
            mode_q <= MD_ARRAY;
        end else if (take) begin
            if (pend_q != PD_NONE) begin
                pend_q <= PD_NONE;
                mode_q <= MD_STATUS;
            end else begin
                unique case (din)
                    CMD_PROG:     pend_q <= PD_PROG;
                    CMD_OTP:      pend_q <= PD_OTP;
                    CMD_ERASE:    pend_q <= PD_ERASE;
                    CMD_STATUS:   mode_q <= MD_STATUS;
                    CMD_ARRAY:    mode_q <= MD_ARRAY;
                    CMD_OTP_READ: mode_q <= MD_OTP;
                    default:      ;
                endcase
            end
        end
    end

    assign mode_o = mode_q;

    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(mode_q) && $stable(pend_q)));

    assert_start_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (mode_q == MD_STATUS));
endmodule

// File: rtl/fcc_wsm.sv
// Write state machine: latches an accepted operation, checks protection
// and voltage at acceptance, counts BUSY_CYCLES, then commits or records
// errors. Holds the sticky status word. Assumes BUSY_CYCLES >= 1.
module fcc_wsm
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_AW     = 3,
    parameter int BUSY_CYCLES = 4,
    parameter bit TOP_BOOT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              clr_i,
    input  logic              seq_err_i,
    input  logic              wp_n,
    input  logic              vpp_ok,
    input  logic              otp_lock,
    output logic              busy_o,
    output logic [7:0]        status_o,
    output logic              main_prog_o,
    output logic              main_erase_o,
    output logic              otp_prog_o,
    output logic [ADDR_W-1:0] w_addr_o,
    output logic [DATA_W-1:0] w_data_o
);
    localparam int BLK_AW     = ADDR_W - WORD_AW;
    localparam int NUM_BLOCKS = 1 << BLK_AW;
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              f_vpp_q, f_lock_q;
    logic              e5_q, e4_q, e3_q, e1_q;
    logic [BLK_AW-1:0] blk;
    logic              boot_hit;
    logic              lock_now;
    logic              done;
    logic              clean;

    assign blk = addr_i[ADDR_W-1 -: BLK_AW];

    generate
        if (TOP_BOOT) begin : g_top
            assign boot_hit = (blk >= BLK_AW'(NUM_BLOCKS - 2));
        end else begin : g_bottom
            assign boot_hit = (blk < BLK_AW'(2));
        end
    endgenerate

    assign lock_now = (op_i == OP_OTP) ? otp_lock : (boot_hit && !wp_n);

    // operation capture and busy countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            f_vpp_q  <= 1'b0;
            f_lock_q <= 1'b0;
        end else if (start_i && !busy_q) begin
            busy_q   <= 1'b1;
            cnt_q    <= CNT_W'(BUSY_CYCLES - 1);
            op_q     <= op_i;
            addr_q   <= addr_i;
            data_q   <= data_i;
            f_vpp_q  <= !vpp_ok;
            f_lock_q <= lock_now;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign done  = busy_q && (cnt_q == '0);
    assign clean = !f_vpp_q && !f_lock_q;

    // sticky error bits: set on failed completion or bad sequence, cleared by command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {e5_q, e4_q, e3_q, e1_q} <= '0;
        end else if (clr_i) begin
            {e5_q, e4_q, e3_q, e1_q} <= '0;
        end else if (seq_err_i) begin
            e5_q <= 1'b1;
            e4_q <= 1'b1;
        end else if (done && !clean) begin
            if (f_vpp_q) e3_q <= 1'b1;
            else         e1_q <= 1'b1;
            if (op_q == OP_ERASE) e5_q <= 1'b1;
            else                  e4_q <= 1'b1;
        end
    end

    assign main_prog_o  = done && clean && (op_q == OP_PROG);
    assign otp_prog_o   = done && clean && (op_q == OP_OTP);
    assign main_erase_o = done && clean && (op_q == OP_ERASE);
    assign w_addr_o     = addr_q;
    assign w_data_o     = data_q;
    assign busy_o       = busy_q;
    assign status_o     = {!busy_q, 1'b0, e5_q, e4_q, e3_q, 1'b0, e1_q, 1'b0};

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);

    assert_vpp_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q && !vpp_ok) |=> f_vpp_q);

    assert_clear_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (status_o[5:3] == 3'b000 && !status_o[1]));

    assert_commit_only_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (main_prog_o || main_erase_o || otp_prog_o) |-> (!f_lock_q && !f_vpp_q && busy_q));
endmodule

// File: rtl/fcc_array.sv
// Storage model: main array of 8-word blocks plus a small OTP area.
// Program ANDs new data into a word; erase fills one block with ones.
// Assumes at most one write strobe per cycle.
module fcc_array
    import fcc_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int WORD_AW = 3,
    parameter int OTP_AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic              erase_i,
    input  logic              otp_prog_i,
    input  logic [ADDR_W-1:0] w_addr_i,
    input  logic [DATA_W-1:0] w_data_i,
    input  logic [ADDR_W-1:0] r_addr_i,
    output logic [DATA_W-1:0] main_q_o,
    output logic [DATA_W-1:0] otp_q_o
);
    localparam int MAIN_WORDS = 1 << ADDR_W;
    localparam int OTP_WORDS  = 1 << OTP_AW;

    logic [DATA_W-1:0] mem_q [MAIN_WORDS];
    logic [DATA_W-1:0] otp_q [OTP_WORDS];
    logic [DATA_W-1:0] old_word;

    assign old_word = mem_q[w_addr_i];

    // main array update: erased state, AND-program, block erase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_WORDS; i++) mem_q[i] <= '1;
        end else if (prog_i) begin
            mem_q[w_addr_i] <= old_word & w_data_i;
        end else if (erase_i) begin
            for (int i = 0; i < MAIN_WORDS; i++)
                if ((ADDR_W'(i) >> WORD_AW) == (w_addr_i >> WORD_AW)) mem_q[i] <= '1;
        end
    end

    // OTP area update: erased state at reset, AND-program only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < OTP_WORDS; i++) otp_q[i] <= '1;
        end else if (otp_prog_i) begin
            otp_q[w_addr_i[OTP_AW-1:0]] <= otp_q[w_addr_i[OTP_AW-1:0]] & w_data_i;
        end
    end

    assign main_q_o = mem_q[r_addr_i];
    assign otp_q_o  = otp_q[r_addr_i[OTP_AW-1:0]];

    assert_prog_clears_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_i |=> ((mem_q[$past(w_addr_i)] | $past(old_word)) == $past(old_word)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top: flash command interface controller. Connects decoder, write state
// machine and storage, and selects read data by the current read mode.
// Assumes synchronous we_n and an 8-bit data bus.
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_AW     = 3,
    parameter int OTP_AW      = 2,
    parameter int BUSY_CYCLES = 4,
    parameter bit TOP_BOOT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              wp_n,
    input  logic              vpp_ok,
    input  logic              otp_lock,
    output logic [7:0]        dout,
    output logic              ry_by
);
    mode_e             mode;
    logic              start, clr, seq_err, busy;
    op_e               op;
    logic [7:0]        status;
    logic              main_prog, main_erase, otp_prog;
    logic [ADDR_W-1:0] w_addr;
    logic [7:0]        w_data;
    logic [7:0]        main_q, otp_q;

    fcc_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
        .busy_i(busy), .mode_o(mode), .start_o(start), .op_o(op),
        .clr_o(clr), .seq_err_o(seq_err)
    );

    fcc_wsm #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .BUSY_CYCLES(BUSY_CYCLES),
              .TOP_BOOT(TOP_BOOT)) u_wsm (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
        .data_i(din), .clr_i(clr), .seq_err_i(seq_err), .wp_n(wp_n),
        .vpp_ok(vpp_ok), .otp_lock(otp_lock), .busy_o(busy), .status_o(status),
        .main_prog_o(main_prog), .main_erase_o(main_erase), .otp_prog_o(otp_prog),
        .w_addr_o(w_addr), .w_data_o(w_data)
    );

    fcc_array #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .OTP_AW(OTP_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_i(main_prog), .erase_i(main_erase),
        .otp_prog_i(otp_prog), .w_addr_i(w_addr), .w_data_i(w_data),
        .r_addr_i(addr), .main_q_o(main_q), .otp_q_o(otp_q)
    );

    // read-data selection by mode
    always_comb begin
        unique case (mode)
            MD_STATUS: dout = status;
            MD_OTP:    dout = otp_q;
            default:   dout = main_q;
        endcase
    end

    assign ry_by = !busy;

    assert_ready_matches_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ry_by == status[7]);
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          wp_n = 1'b1, vpp_ok = 1'b1, otp_lock = 1'b0;
    logic [7:0]    dout;
    logic          ry_by;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
        .wp_n(wp_n), .vpp_ok(vpp_ok), .otp_lock(otp_lock),
        .dout(dout), .ry_by(ry_by)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // fields: cmd1(8) two(1) addr(6) byte2(8) wp_n vpp_ok lock status(8)
    localparam logic [33:0] VEC [19] = '{
        {8'h40,1'b1,6'd5, 8'hA5,1'b1,1'b1,1'b0,8'h80}, // R2 plain program
        {8'h40,1'b1,6'd50,8'h0F,1'b0,1'b1,1'b0,8'h92}, // R8 boot program blocked
        {8'h40,1'b1,6'd6, 8'h77,1'b1,1'b1,1'b0,8'h92}, // R11 errors persist
        {8'h50,1'b0,6'd0, 8'h00,1'b1,1'b1,1'b0,8'h80}, // R11 clear
        {8'h40,1'b1,6'd50,8'h0F,1'b1,1'b1,1'b0,8'h80}, // R9 boot program with wp high
        {8'h40,1'b1,6'd3, 8'h00,1'b1,1'b0,1'b0,8'h98}, // R6 voltage low program
        {8'h50,1'b0,6'd0, 8'h00,1'b1,1'b1,1'b0,8'h80},
        {8'h20,1'b1,6'd20,8'hD0,1'b1,1'b0,1'b0,8'hA8}, // R6 voltage low erase
        {8'h50,1'b0,6'd0, 8'h00,1'b1,1'b1,1'b0,8'h80},
        {8'hC0,1'b1,6'd1, 8'h3C,1'b1,1'b1,1'b0,8'h80}, // R3 OTP program
        {8'hC0,1'b1,6'd2, 8'h00,1'b1,1'b1,1'b1,8'h92}, // R7 OTP locked
        {8'h50,1'b0,6'd0, 8'h00,1'b1,1'b1,1'b0,8'h80},
        {8'hC0,1'b1,6'd1, 8'h0F,1'b0,1'b1,1'b0,8'h80}, // R9 wp ignored for OTP
        {8'h20,1'b1,6'd60,8'hD0,1'b0,1'b1,1'b0,8'hA2}, // R8 boot erase blocked
        {8'h50,1'b0,6'd0, 8'h00,1'b1,1'b1,1'b0,8'h80},
        {8'h40,1'b1,6'd10,8'h5A,1'b0,1'b1,1'b0,8'h80}, // R9 non-boot with wp low
        {8'h20,1'b1,6'd50,8'hD0,1'b1,1'b1,1'b0,8'h80}, // R10 erase boot block, wp high
        {8'h20,1'b1,6'd0, 8'h00,1'b1,1'b1,1'b0,8'hB0}, // R10 bad confirm
        {8'h50,1'b0,6'd0, 8'h00,1'b1,1'b1,1'b0,8'h80}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 100 && !ry_by; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a;
        @(negedge clk); v = dout;
    endtask

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {7'd0, ry_by}, 8'h01);
        rd(6'd0, v);  check("R1 main erased", v, 8'hFF);
        rd(6'd63, v); check("R1 main erased top", v, 8'hFF);
        wr(6'd0, 8'h90); rd(6'd3, v); check("R1 otp erased", v, 8'hFF);
        wr(6'd0, 8'h70); rd(6'd0, v); check("R1 status", v, 8'h80);

        // table walk
        for (int k = 0; k < 19; k++) begin
            logic [33:0] e;
            e = VEC[k];
            @(negedge clk);
            wp_n = e[10]; vpp_ok = e[9]; otp_lock = e[8];
            wr(e[24:19], e[33:26]);
            if (e[25]) wr(e[24:19], e[18:11]);
            wait_ready();
            wr(6'd0, 8'h70);
            rd(6'd0, v);
            check($sformatf("R11 table vector %0d status", k), v, e[7:0]);
        end
        wp_n = 1'b1; vpp_ok = 1'b1; otp_lock = 1'b0;

        // array contents after table
        wr(6'd0, 8'hFF);
        rd(6'd5, v);  check("R2 programmed word", v, 8'hA5);
        rd(6'd6, v);  check("R2 word after failed op", v, 8'h77);
        rd(6'd3, v);  check("R6 unchanged on low voltage", v, 8'hFF);
        rd(6'd10, v); check("R9 non-boot with wp low", v, 8'h5A);
        rd(6'd50, v); check("R10 erased boot word", v, 8'hFF);
        rd(6'd60, v); check("R8 protected block stays", v, 8'hFF);
        wr(6'd0, 8'h90);
        rd(6'd1, v);  check("R3 OTP AND result", v, 8'h0C);
        rd(6'd2, v);  check("R7 locked OTP unchanged", v, 8'hFF);

        // R4 busy length and status bit 7 during run
        wr(6'd0, 8'h40);
        wr(6'd5, 8'hF0);
        n = 0;
        v = dout;
        check("R4 status bit7 busy", v & 8'h80, 8'h00);
        for (int i = 0; i < 100 && !ry_by; i++) begin n++; @(negedge clk); end
        check("R4 busy cycles", 8'(n), 8'd4);
        // R5 status persists without a command
        rd(6'd0, v); check("R5 status after op", v, 8'h80);

        // R12 write during busy ignored
        wr(6'd0, 8'h40);
        wr(6'd7, 8'h11);
        wr(6'd0, 8'hFF);
        wait_ready();
        rd(6'd7, v); check("R12 mode kept after busy write", v, 8'h80);

        wr(6'd0, 8'hFF);
        rd(6'd5, v); check("R2 AND of second program", v, 8'hA0);
        rd(6'd7, v); check("R12 op itself still ran", v, 8'h11);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule